// File: doc/BRIEF.md
# Performance Monitor Counter Unit

This block counts hardware events for profiling. It holds a set of 32-bit event counters, set by a parameter, and one separate 32-bit cycle counter. Each event counter is given an 8-bit event number. The number picks one line of a per-cycle event pulse bus, or one of two built-in sources: every clock, or a software increment. Each counter also carries filter bits that stop counting at chosen privilege levels. A counter that wraps past all-ones sets an overflow flag. One level-sensitive interrupt line is raised while any flag is set whose interrupt enable is also set.

Software uses a small synchronous register port with a word address, a write strobe, write data and combinational read data. Enable masks and interrupt masks each have one address that sets bits and another that clears them. Overflow flags are cleared by writing 1 to them. The event counters are reached indirectly: a select register picks one counter, and then two windows read or write that counter's event type and its value. The cycle counter can also be read and written at its own address.

Top module: `pmu_monitor`

Word addresses: 0 control, 1 enable-set, 2 enable-clear, 3 interrupt-enable-set, 4 interrupt-enable-clear, 5 overflow flags, 6 software increment, 7 counter select, 8 event-type window, 9 value window, 10 cycle counter.

## Requirements
- R1: After reset, every enable, interrupt-enable and overflow bit is zero. All counters and the select register are zero, and `irq` is low. The control register reads back as the counter count in bits 15:11 and zero in every other bit.
- R2: In the control register, bit 0 is the global enable. Bit 3 divides the cycle counter clock by 64. Bits 4 and 5 are stored and have no effect. These four bits read back as written. Writing 1 to bit 1 zeroes every event counter and leaves the cycle counter unchanged. Writing 1 to bit 2 zeroes the cycle counter and its divider. Bits 1 and 2 read 0. Bits 15:11 are read-only and give NUM_EVT.
- R3: Enable bits and interrupt-enable bits each have a set address and a clear address. A 1 in the written data sets or clears only that bit, and a 0 leaves it unchanged. Both addresses read the current mask. Bit n belongs to event counter n and bit 31 to the cycle counter. Bits of counters that are not implemented always read 0.
- R4: An event counter adds one on a clock edge only when all four of these hold: the global enable is set, its own enable bit is set, its selected event is active, and the current privilege level is not filtered out.
- R5: Event number 0x11 is active on every cycle. Event 0x00 is active only in a cycle that writes the software increment register with a 1 in that counter's bit. Any other number n is active when `ev_bus[n]` is high, and is never active when n >= EV_W.
- R6: Event-type bit 31 blocks counting at privilege level 1, and bit 30 blocks counting at level 0. Privilege levels 2 and 3 count only when bit 27 is set.
- R7: When a counter steps from 0xFFFFFFFF to 0, its overflow bit is set: bit n for event counter n, bit 31 for the cycle counter. A flag stays set until it is cleared by writing 1 to it at address 5.
- R8: `irq` is high exactly while some overflow bit and the interrupt-enable bit at the same position are both set.
- R9: The cycle counter counts while the global enable and enable bit 31 are both set. With bit 3 clear it adds one per clock. With bit 3 set it adds one on every 64th enabled clock, counted from the last divider clear.
- R10: The select register keeps a 5-bit index. The value window at index 31 reaches the cycle counter. At the index of an unimplemented counter, both windows read 0 and ignore writes.
- R11: When a counter is written in a cycle where it would also increment, the written value wins and no overflow flag is set.
- R12: Only event-type bits 31, 30, 27 and 7:0 are writable. Bits 7:0 hold the event number, and all other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 4 | Register word address |
| we | input | 1 | Write strobe |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| ev_bus | input | EV_W | Event pulses, one line per event number |
| priv | input | 2 | Current privilege level |
| irq | output | 1 | Overflow interrupt, level |

## Verification
The bench aims at the wrap edge. It preloads 0xFFFFFFFE and pulses the event twice, so a design that sets the flag one step early or late, or fails to raise `irq`, is caught. A second case writes a counter that is sitting at all-ones while it is counting; a design that lets the increment win shows a stray overflow flag and a wrong value. Window counts are checked to the exact cycle for the every-clock event and for the divide-by-64 cycle counter, which exposes any off-by-one in enable timing or divider phase. Random phases then vary event lines, filter bits and privilege levels, and catch filter polarity errors or a missing check of privilege level 2.

// File: rtl/pmu_pkg.sv
// Shared constants and helpers for the performance monitor.
// Assumes 32-bit counters and a 4-bit word address map.
package pmu_pkg;
    localparam int          CNT_W    = 32;
    localparam int          ADDR_W   = 4;
    localparam int          CYC_BIT  = 31;
    localparam logic [31:0] TYPE_WMASK = 32'hC80000FF;
    localparam logic [7:0]  EV_CYCLES  = 8'h11;
    localparam logic [7:0]  EV_SOFT    = 8'h00;

    localparam logic [ADDR_W-1:0] A_CTRL  = 4'd0;
    localparam logic [ADDR_W-1:0] A_ENSET = 4'd1;
    localparam logic [ADDR_W-1:0] A_ENCLR = 4'd2;
    localparam logic [ADDR_W-1:0] A_IESET = 4'd3;
    localparam logic [ADDR_W-1:0] A_IECLR = 4'd4;
    localparam logic [ADDR_W-1:0] A_OVF   = 4'd5;
    localparam logic [ADDR_W-1:0] A_SWINC = 4'd6;
    localparam logic [ADDR_W-1:0] A_SEL   = 4'd7;
    localparam logic [ADDR_W-1:0] A_TYPE  = 4'd8;
    localparam logic [ADDR_W-1:0] A_VALUE = 4'd9;
    localparam logic [ADDR_W-1:0] A_CYCLE = 4'd10;

    // Privilege filter: level 0 by bit 30, level 1 by bit 31, levels 2/3 need bit 27.
    function automatic logic priv_allows(input logic [31:0] t, input logic [1:0] pl);
        case (pl)
            2'd0:    priv_allows = !t[30];
            2'd1:    priv_allows = !t[31];
            default: priv_allows = t[27];
        endcase
    endfunction
endpackage

// File: rtl/pmu_evt_ctr.sv
// One event counter: event-type register, 32-bit value, wrap detect.
// Assumes the parent gates 'run' with global and per-counter enables.
module pmu_evt_ctr
    import pmu_pkg::*;
#(
    parameter int EV_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [EV_W-1:0]  ev_bus,
    input  logic             soft_inc,
    input  logic [1:0]       priv,
    input  logic             type_we,
    input  logic [31:0]      type_wd,
    input  logic             val_we,
    input  logic [CNT_W-1:0] val_wd,
    input  logic             zero,
    output logic [31:0]      type_q,
    output logic [CNT_W-1:0] val_q,
    output logic             wrap
);
    logic [7:0]      evnum;
    logic [EV_W-1:0] onehot;
    logic            hit, step;

    assign evnum  = type_q[7:0];
    assign onehot = {{(EV_W-1){1'b0}}, 1'b1} << evnum;

    // Decode the selected event source for this cycle.
    always_comb begin
        if (evnum == EV_CYCLES)    hit = 1'b1;
        else if (evnum == EV_SOFT) hit = soft_inc;
        else                       hit = |(ev_bus & onehot);
    end

    assign step = run && hit && priv_allows(type_q, priv);
    assign wrap = step && !val_we && !zero && (val_q == '1);

    // Event-type register with writable-bit mask.
    always_ff @(posedge clk) begin
        if (!rst_n)       type_q <= '0;
        else if (type_we) type_q <= type_wd & TYPE_WMASK;
    end

    // Counter value: write wins over clear wins over step.
    always_ff @(posedge clk) begin
        if (!rst_n)      val_q <= '0;
        else if (val_we) val_q <= val_wd;
        else if (zero)   val_q <= '0;
        else if (step)   val_q <= val_q + 1'b1;
    end

    // R4
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !val_we && !zero) |=> $stable(val_q));
    // R11
    write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        val_we |=> (val_q == $past(val_wd)));
    // R7
    wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (val_q == '0));
endmodule

// File: rtl/pmu_cyc_ctr.sv
// Dedicated cycle counter with optional divide-by-2^PRE_W prescaler.
// Assumes 'zero' also restarts the prescaler phase.
module pmu_cyc_ctr
    import pmu_pkg::*;
#(
    parameter int PRE_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             slow,
    input  logic             val_we,
    input  logic [CNT_W-1:0] val_wd,
    input  logic             zero,
    output logic [CNT_W-1:0] val_q,
    output logic             wrap
);
    logic [PRE_W-1:0] pre_q;
    logic             tick;

    assign tick = run && (!slow || (pre_q == '1));
    assign wrap = tick && !val_we && !zero && (val_q == '1);

    // Prescaler advances only while running in divided mode.
    always_ff @(posedge clk) begin
        if (!rst_n || zero)    pre_q <= '0;
        else if (run && slow)  pre_q <= pre_q + 1'b1;
    end

    // Cycle value: write, then clear, then tick.
    always_ff @(posedge clk) begin
        if (!rst_n)      val_q <= '0;
        else if (val_we) val_q <= val_wd;
        else if (zero)   val_q <= '0;
        else if (tick)   val_q <= val_q + 1'b1;
    end

    // R9
    full_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !slow && !val_we && !zero) |=> (val_q == $past(val_q) + 1'b1));
endmodule

// File: rtl/pmu_monitor.sv
// Performance monitor top: register file, enables, overflow flags, IRQ.
// Assumes NUM_EVT in 1..31 and a single-cycle register write strobe.
module pmu_monitor
    import pmu_pkg::*;
#(
    parameter int NUM_EVT = 4,
    parameter int EV_W    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    input  logic [EV_W-1:0]   ev_bus,
    input  logic [1:0]        priv,
    output logic              irq
);
    localparam logic [4:0] NEV = 5'(NUM_EVT);

    function automatic logic [31:0] impl_mask();
        logic [31:0] m = '0;
        for (int i = 0; i < NUM_EVT; i++) m[i] = 1'b1;
        m[CYC_BIT] = 1'b1;
        return m;
    endfunction
    localparam logic [31:0] IMPL = impl_mask();

    logic        en_q, div_q;
    logic [1:0]  spare_q;
    logic [31:0] cnten_q, inten_q, ovf_q, wraps, soft_vec;
    logic [4:0]  sel_q;
    logic [31:0]      type_arr [31];
    logic [CNT_W-1:0] val_arr  [31];
    logic [CNT_W-1:0] cyc_val;
    logic [31:0] type_win, val_win;

    logic wr_ctrl, wr_enset, wr_enclr, wr_ieset, wr_ieclr, wr_ovf, wr_swinc;
    logic wr_sel, wr_type, wr_val, wr_cyc, p_pulse, c_pulse;

    assign wr_ctrl  = we && (addr == A_CTRL);
    assign wr_enset = we && (addr == A_ENSET);
    assign wr_enclr = we && (addr == A_ENCLR);
    assign wr_ieset = we && (addr == A_IESET);
    assign wr_ieclr = we && (addr == A_IECLR);
    assign wr_ovf   = we && (addr == A_OVF);
    assign wr_swinc = we && (addr == A_SWINC);
    assign wr_sel   = we && (addr == A_SEL);
    assign wr_type  = we && (addr == A_TYPE);
    assign wr_val   = we && (addr == A_VALUE);
    assign wr_cyc   = we && (addr == A_CYCLE);
    assign p_pulse  = wr_ctrl && wdata[1];
    assign c_pulse  = wr_ctrl && wdata[2];
    assign soft_vec = wr_swinc ? wdata : '0;

    // Control register: stored bits 0, 3, 5:4.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= 1'b0; div_q <= 1'b0; spare_q <= '0;
        end else if (wr_ctrl) begin
            en_q <= wdata[0]; div_q <= wdata[3]; spare_q <= wdata[5:4];
        end
    end

    // Counter-enable and interrupt-enable masks with set/clear access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnten_q <= '0; inten_q <= '0;
        end else begin
            if (wr_enset) cnten_q <= cnten_q | (wdata & IMPL);
            if (wr_enclr) cnten_q <= cnten_q & ~wdata;
            if (wr_ieset) inten_q <= inten_q | (wdata & IMPL);
            if (wr_ieclr) inten_q <= inten_q & ~wdata;
        end
    end

    // Overflow flags: new wraps win over a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n) ovf_q <= '0;
        else        ovf_q <= (ovf_q & ~(wr_ovf ? wdata : 32'h0)) | wraps;
    end

    // Counter select register.
    always_ff @(posedge clk) begin
        if (!rst_n)      sel_q <= '0;
        else if (wr_sel) sel_q <= wdata[4:0];
    end

    for (genvar i = 0; i < 31; i++) begin : g_ctr
        if (i < NUM_EVT) begin : g_impl
            pmu_evt_ctr #(.EV_W(EV_W)) u_ctr (
                .clk(clk), .rst_n(rst_n),
                .run(en_q && cnten_q[i]), .ev_bus(ev_bus),
                .soft_inc(soft_vec[i]), .priv(priv),
                .type_we(wr_type && (sel_q == 5'(i))), .type_wd(wdata),
                .val_we(wr_val && (sel_q == 5'(i))), .val_wd(wdata),
                .zero(p_pulse), .type_q(type_arr[i]), .val_q(val_arr[i]),
                .wrap(wraps[i]));
        end else begin : g_none
            assign type_arr[i] = '0;
            assign val_arr[i]  = '0;
            assign wraps[i]    = 1'b0;
        end
    end

    pmu_cyc_ctr #(.PRE_W(6)) u_cyc (
        .clk(clk), .rst_n(rst_n),
        .run(en_q && cnten_q[CYC_BIT]), .slow(div_q),
        .val_we(wr_cyc || (wr_val && (sel_q == 5'd31))), .val_wd(wdata),
        .zero(c_pulse), .val_q(cyc_val), .wrap(wraps[CYC_BIT]));

    // Indirect window read selection.
    always_comb begin
        if (sel_q == 5'd31) begin
            type_win = '0; val_win = cyc_val;
        end else begin
            type_win = type_arr[sel_q]; val_win = val_arr[sel_q];
        end
    end

    // Register read multiplexer.
    always_comb begin
        case (addr)
            A_CTRL:           rdata = {16'h0, NEV, 5'h0, spare_q, div_q, 2'b00, en_q};
            A_ENSET, A_ENCLR: rdata = cnten_q;
            A_IESET, A_IECLR: rdata = inten_q;
            A_OVF:            rdata = ovf_q;
            A_SEL:            rdata = {27'h0, sel_q};
            A_TYPE:           rdata = type_win;
            A_VALUE:          rdata = val_win;
            A_CYCLE:          rdata = cyc_val;
            default:          rdata = '0;
        endcase
    end

    assign irq = |(ovf_q & inten_q);

    // R3
    enable_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_enclr |=> ((cnten_q & $past(cnten_q)) == $past(cnten_q)));
    // R7
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ovf |=> ((ovf_q & $past(ovf_q)) == $past(ovf_q)));
    // R8
    irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(wr_ovf || wr_ieclr));
endmodule

// File: tb/sim_pmu_monitor.sv
module sim_pmu_monitor;
    localparam int NE = 4;
    localparam logic [3:0] CTRL=0, ENSET=1, ENCLR=2, IESET=3, IECLR=4, OVF=5,
                           SWINC=6, SEL=7, TYPE=8, VALUE=9, CYCLE=10;

    logic clk = 1'b0, rst_n = 1'b0, we = 1'b0, irq;
    logic [3:0] addr = '0;
    logic [31:0] wdata = '0, rdata, ev_bus = '0;
    logic [1:0] priv = '0;
    int checks = 0, fails = 0, cyc = 0;
    bit done = 0;

    pmu_monitor #(.NUM_EVT(NE), .EV_W(32)) u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .we(we), .wdata(wdata),
        .rdata(rdata), .ev_bus(ev_bus), .priv(priv), .irq(irq));

    always #4 clk = ~clk;

    function automatic bit m_allow(input logic [31:0] t, input logic [1:0] pl);
        if (pl == 0) return !t[30];
        if (pl == 1) return !t[31];
        return t[27];
    endfunction

    function automatic bit m_hit(input logic [31:0] t, input logic [31:0] bus);
        if (t[7:0] == 8'h11) return 1;
        if (t[7:0] == 8'h00) return 0;
        if (t[7:0] >= 32) return 0;
        return bus[t[4:0]];
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Called at a negedge; returns at the following negedge.
    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        addr = a; we = 1'b0;
        #1 d = rdata;
        @(negedge clk);
    endtask

    task automatic rdchk(input string req, input logic [3:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                fails++;
                $display("FAIL watchdog expired");
                finish_run();
            end
        end
    end

    initial begin
        logic [31:0] v, c0, m, t;
        logic [31:0] tq [NE];
        int exp_c [NE];
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rdchk("R1 ctrl", CTRL, 32'h0000_2000);
        rdchk("R1 enable", ENSET, 0);
        rdchk("R1 inten", IESET, 0);
        rdchk("R1 ovf", OVF, 0);
        rdchk("R1 sel", SEL, 0);
        rdchk("R1 value", VALUE, 0);
        rdchk("R1 cycle", CYCLE, 0);
        chk("R1 irq", {31'h0, irq}, 0);

        // R2 control readback
        wr(CTRL, 32'hFFFF_FFFF);
        rdchk("R2 ctrl readback", CTRL, 32'h0000_2039);
        wr(CTRL, 0);

        // R3 set/clear masks
        wr(ENSET, 32'hFFFF_FFFF);
        rdchk("R3 set", ENSET, 32'h8000_000F);
        wr(ENCLR, 32'h2);
        rdchk("R3 clear", ENCLR, 32'h8000_000D);
        wr(IESET, 32'h0000_0104);
        rdchk("R3 inten set", IECLR, 32'h0000_0004);
        wr(IECLR, 32'hFFFF_FFFF);
        wr(ENCLR, 32'hFFFF_FFFF);
        rdchk("R3 all clear", ENSET, 0);

        // R12 type mask, R10 unimplemented index
        wr(SEL, 0); wr(TYPE, 32'hFFFF_FFFF);
        rdchk("R12 type mask", TYPE, 32'hC800_00FF);
        wr(SEL, 10); wr(TYPE, 32'h11); wr(VALUE, 7);
        rdchk("R10 unimpl type", TYPE, 0);
        rdchk("R10 unimpl value", VALUE, 0);

        // R5 every-clock event; R4 gating by own enable and global enable
        wr(SEL, 0); wr(TYPE, 32'h11);
        wr(SEL, 1); wr(TYPE, 32'h11);
        wr(ENSET, 32'h1);
        wr(CTRL, 1); idle(20); wr(CTRL, 0);
        idle(10);
        wr(SEL, 0); rdchk("R5 cycles event", VALUE, 21);
        wr(SEL, 1); rdchk("R4 own enable off", VALUE, 0);

        // R9 cycle counter full rate and divided
        wr(ENCLR, 32'h1); wr(ENSET, 32'h8000_0000);
        wr(CTRL, 32'h5); idle(29); wr(CTRL, 0);
        rdchk("R9 full rate", CYCLE, 30);
        wr(SEL, 31); rdchk("R10 sel 31 is cycle", VALUE, 30);
        wr(CTRL, 32'hD); idle(126); wr(CTRL, 0);
        rdchk("R9 divide by 64", CYCLE, 1);
        wr(CYCLE, 32'h55); rdchk("R10 cycle direct write", CYCLE, 32'h55);

        // R5 software increment; R4 global enable gates it
        wr(ENCLR, 32'hFFFF_FFFF);
        wr(SEL, 1); wr(TYPE, 0); wr(ENSET, 32'h2);
        wr(SWINC, 32'h2);
        wr(CTRL, 1);
        wr(SWINC, 32'h2); wr(SWINC, 32'h3); wr(SWINC, 32'h2);
        wr(CTRL, 0);
        rdchk("R5 soft inc", VALUE, 3);

        // R11 write wins at the wrap edge, no flag
        wr(ENCLR, 32'hFFFF_FFFF);
        wr(SEL, 2); wr(TYPE, 32'h11); wr(VALUE, 32'hFFFF_FFFF);
        wr(ENSET, 32'h4);
        wr(CTRL, 1); wr(VALUE, 5); wr(CTRL, 0);
        rdchk("R11 value", VALUE, 6);
        rdchk("R11 no flag", OVF, 0);

        // R2 event-counter reset keeps cycle counter
        rd(CYCLE, c0);
        wr(CTRL, 32'h2);
        wr(SEL, 1); rdchk("R2 P clears ctr1", VALUE, 0);
        wr(SEL, 2); rdchk("R2 P clears ctr2", VALUE, 0);
        rdchk("R2 P keeps cycle", CYCLE, c0);
        wr(CTRL, 32'h4);
        rdchk("R2 C clears cycle", CYCLE, 0);

        // R7 overflow and R8 interrupt
        wr(ENCLR, 32'hFFFF_FFFF);
        wr(SEL, 0); wr(TYPE, 32'h5); wr(VALUE, 32'hFFFF_FFFE);
        wr(ENSET, 32'h1); wr(IESET, 32'h1);
        wr(CTRL, 1);
        ev_bus = 32'h20; idle(2); ev_bus = 0;
        wr(CTRL, 0);
        rdchk("R7 wrapped value", VALUE, 0);
        rdchk("R7 flag set", OVF, 32'h1);
        chk("R8 irq high", {31'h0, irq}, 1);
        idle(5);
        rdchk("R7 flag sticky", OVF, 32'h1);
        wr(OVF, 32'h1);
        rdchk("R7 flag cleared", OVF, 0);
        chk("R8 irq low", {31'h0, irq}, 0);
        wr(IECLR, 32'hFFFF_FFFF);

        // R6 directed privilege filter
        wr(TYPE, 32'h8000_0011); wr(VALUE, 0);
        priv = 2'd1; wr(CTRL, 1); idle(8); wr(CTRL, 0);
        rdchk("R6 level1 blocked", VALUE, 0);
        priv = 2'd2; wr(CTRL, 1); idle(8); wr(CTRL, 0);
        rdchk("R6 level2 excluded", VALUE, 0);
        priv = 2'd0; wr(CTRL, 1); idle(8); wr(CTRL, 0);
        rdchk("R6 level0 counts", VALUE, 9);
        wr(TYPE, 32'h0800_0011); priv = 2'd3;
        wr(CTRL, 1); idle(4); wr(CTRL, 0);
        rdchk("R6 level3 with bit27", VALUE, 14);

        // R4 R5 R6 random phases
        for (int r = 0; r < 4; r++) begin
            wr(CTRL, 32'h2);
            for (int i = 0; i < NE; i++) begin
                t = 32'(1 + ($urandom % 31));
                if (t == 32'h11) t = 32'h12;
                if (($urandom % 8) == 0) t = 32'h40;
                t = t | ($urandom & 32'hC800_0000);
                tq[i] = t;
                exp_c[i] = 0;
                wr(SEL, 32'(i)); wr(TYPE, t);
            end
            m = $urandom & 32'hF;
            wr(ENCLR, 32'hFFFF_FFFF); wr(ENSET, m);
            wr(CTRL, 1);
            for (int c = 0; c < 400; c++) begin
                ev_bus = $urandom;
                priv = 2'($urandom % 4);
                for (int i = 0; i < NE; i++)
                    if (m[i] && m_hit(tq[i], ev_bus) && m_allow(tq[i], priv))
                        exp_c[i]++;
                @(negedge clk);
            end
            ev_bus = 0;
            wr(CTRL, 0);
            for (int i = 0; i < NE; i++) begin
                wr(SEL, 32'(i));
                rd(VALUE, v);
                chk($sformatf("R4 R5 R6 random ctr%0d", i), v, 32'(exp_c[i]));
            end
        end

        finish_run();
    end
endmodule